// File: doc/BRIEF.md
# Eight-bit Function-Coded Arithmetic/Logic Unit

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor. It takes two operands and a 4-bit function code, and it drives an 8-bit result. Operand A comes from the processor's fixed source register. Operand B comes from whichever data register the instruction selects.

The block provides two-operand arithmetic (sum and difference), two-operand bit logic, three shift forms and a signed comparison. It also provides two single-operand operations that act on B alone: complement and negation. A separate flag reports whether the two operands are identical. The flag does not depend on the function code, so branch logic can read it at the same time as any other operation.

Arithmetic wraps modulo 2^DATA_W. There is no carry or overflow output. Function codes that are not assigned drive a zero result.

Top module: `alu8_core`

## Requirements
- R1: With function code 0, result_o equals (a_i + b_i) modulo 256.
- R2: With function code 1, result_o equals (a_i - b_i) modulo 256.
- R3: Function code 2 gives the bitwise OR of a_i and b_i. Function code 3 gives the bitwise AND of a_i and b_i.
- R4: Function code 4 shifts a_i left by the shift amount and fills vacated low bits with zeros.
- R5: With function code 5, result_o is 8'd1 when a_i is less than b_i as signed two's-complement values, and 8'd0 otherwise.
- R6: Function code 6 shifts a_i right by the shift amount and fills vacated high bits with zeros.
- R7: Function code 7 shifts a_i right by the shift amount and fills vacated high bits with copies of a_i[7].
- R8: With function code 11, result_o equals the bitwise complement of b_i. a_i has no effect.
- R9: With function code 12, result_o equals (0 - b_i) modulo 256. a_i has no effect.
- R10: The shift amount is b_i[2:0]. Bits b_i[7:3] have no effect on codes 4, 6 and 7, so an amount of 8 or more wraps and does not force zero.
- R11: equal_o is 1 exactly when a_i equals b_i, for every function code.
- R12: Function codes 8, 9, 10, 13, 14 and 15 drive result_o to 8'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (fixed source register) |
| b_i | input | 8 | Second operand (selected data register) |
| funct_i | input | 4 | Function code |
| result_o | output | 8 | Operation result |
| equal_o | output | 1 | High when the operands are identical |

## Verification
The bench builds the block with its default parameters: DATA_W=8, which gives a 3-bit shift amount. At this width, random B values routinely exceed 7, so the wrap of the shift amount (R10) is exercised without special effort. The signed-compare boundaries at 8'h7F and 8'h80 are also reached directly.

Random operands are drawn across all sixteen function codes, which covers the unassigned codes as well as the defined ones. Directed vectors add the following cases:
- equal operands, including 0/0 and 8'hFF/8'hFF;
- negation of zero and of 8'h80;
- arithmetic right shift of negative values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_OR  = 4'd2,
    FN_AND = 4'd3,
    FN_SLL = 4'd4,
    FN_SLT = 4'd5,
    FN_SRL = 4'd6,
    FN_SRA = 4'd7,
    FN_NOT = 4'd11,
    FN_NEG = 4'd12
  } funct_e;

  typedef enum int {
    SH_LEFT  = 0,
    SH_LOGIC = 1,
    SH_ARITH = 2
  } shift_lane_e;

  localparam int NUM_SH_LANES = 3;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic [DATA_W-1:0] neg_o,
  output logic              lt_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_inv;
  logic              ovf;

  assign b_inv  = ~b_i;
  assign sum_o  = a_i + b_i;
  // subtract as a + ~b + 1 so both sum paths share one adder style
  assign diff_o = a_i + b_inv + {{(DATA_W-1){1'b0}}, 1'b1};
  assign neg_o  = b_inv + {{(DATA_W-1){1'b0}}, 1'b1};

  // signed overflow of a - b: operand signs differ and the result sign differs from a
  assign ovf  = (a_i[MSB] ^ b_i[MSB]) & (diff_o[MSB] ^ a_i[MSB]);
  assign lt_o = diff_o[MSB] ^ ovf;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r5_lt_signed: assert (lt_o == ($signed(a_i) < $signed(b_i)))
        else $error("R5 lt mismatch");
      a_r2_diff_roundtrip: assert (DATA_W'(diff_o + b_i) == a_i)
        else $error("R2 diff does not invert sum");
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] sll_o,
  output logic [DATA_W-1:0] srl_o,
  output logic [DATA_W-1:0] sra_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] lane_out [NUM_SH_LANES];
  logic [DATA_W-1:0] left_rev;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) a_rev[i] = a_i[MSB-i];
  end

  // each lane is a log-stage right shifter; left shift runs on the bit-reversed operand
  for (genvar l = 0; l < NUM_SH_LANES; l++) begin : g_lane
    logic [DATA_W-1:0] stage [SH_W+1];
    logic              fill;

    if (l == SH_LEFT) begin : g_src_rev
      assign stage[0] = a_rev;
    end else begin : g_src_fwd
      assign stage[0] = a_i;
    end

    if (l == SH_ARITH) begin : g_fill_sign
      assign fill = a_i[MSB];
    end else begin : g_fill_zero
      assign fill = 1'b0;
    end

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stage[s+1] = amt_i[s]
        ? {{STEP{fill}}, stage[s][MSB:STEP]}
        : stage[s];
    end

    assign lane_out[l] = stage[SH_W];
  end

  assign left_rev = lane_out[SH_LEFT];
  always_comb begin
    for (int i = 0; i < DATA_W; i++) sll_o[i] = left_rev[MSB-i];
  end
  assign srl_o = lane_out[SH_LOGIC];
  assign sra_o = lane_out[SH_ARITH];

  always_comb begin
    if (!$isunknown({a_i, amt_i})) begin
      a_r7_sign_kept: assert (sra_o[MSB] == a_i[MSB])
        else $error("R7 sign bit lost");
      a_r6_top_zero: assert ((amt_i == '0) || (srl_o[MSB] == 1'b0))
        else $error("R6 logical shift filled with one");
      a_r4_low_zero: assert ((amt_i == '0) || (sll_o[0] == 1'b0))
        else $error("R4 left shift filled with one");
      a_r6_r7_agree_positive: assert (a_i[MSB] || (srl_o == sra_o))
        else $error("R7 shifts differ on non-negative operand");
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] not_o,
  output logic              eq_o
);
  assign or_o  = a_i | b_i;
  assign and_o = a_i & b_i;
  assign not_o = ~b_i;
  assign eq_o  = ~|(a_i ^ b_i);

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r3_and_within_or: assert ((and_o & ~or_o) == '0)
        else $error("R3 and/or inconsistent");
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FUNC_W-1:0] funct_i,
  output logic [DATA_W-1:0] result_o,
  output logic              equal_o
);
  logic [DATA_W-1:0] sum, diff, neg, or_r, and_r, not_r;
  logic [DATA_W-1:0] sll, srl, sra;
  logic              lt;

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i),
    .sum_o(sum), .diff_o(diff), .neg_o(neg), .lt_o(lt)
  );

  // only the low bits of b set the shift amount, so large amounts wrap
  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i(a_i), .amt_i(b_i[SH_W-1:0]),
    .sll_o(sll), .srl_o(srl), .sra_o(sra)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i),
    .or_o(or_r), .and_o(and_r), .not_o(not_r), .eq_o(equal_o)
  );

  always_comb begin
    unique case (funct_i)
      FN_ADD:  result_o = sum;
      FN_SUB:  result_o = diff;
      FN_OR:   result_o = or_r;
      FN_AND:  result_o = and_r;
      FN_SLL:  result_o = sll;
      FN_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt};
      FN_SRL:  result_o = srl;
      FN_SRA:  result_o = sra;
      FN_NOT:  result_o = not_r;
      FN_NEG:  result_o = neg;
      default: result_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, funct_i})) begin
      a_r12_reserved_zero: assert (!(funct_i inside {4'd8, 4'd9, 4'd10, 4'd13, 4'd14, 4'd15})
                                   || (result_o == '0))
        else $error("R12 reserved code nonzero");
      a_r5_slt_boolean: assert ((funct_i != FN_SLT) || (result_o <= DATA_W'(1)))
        else $error("R5 slt not boolean");
      a_r11_equal_vs_diff: assert (equal_o == (diff == '0))
        else $error("R11 equal flag disagrees with difference");
      a_r9_neg_is_not_plus_one: assert (neg == DATA_W'(not_r + 1'b1))
        else $error("R9 negate inconsistent with complement");
    end
  end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic [3:0] fn;
  logic       eq;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alu8_core dut_i (
    .a_i(a), .b_i(b), .funct_i(fn), .result_o(res), .equal_o(eq)
  );

  function automatic logic [7:0] model(input logic [7:0] x, input logic [7:0] y,
                                       input logic [3:0] f);
    logic [2:0] sh = y[2:0];
    case (f)
      4'd0:    return x + y;
      4'd1:    return x - y;
      4'd2:    return x | y;
      4'd3:    return x & y;
      4'd4:    return x << sh;
      4'd5:    return ($signed(x) < $signed(y)) ? 8'd1 : 8'd0;
      4'd6:    return x >> sh;
      4'd7:    return 8'($signed(x) >>> sh);
      4'd11:   return ~y;
      4'd12:   return 8'(0) - y;
      default: return 8'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4 R10";
      4'd5: return "R5";
      4'd6: return "R6 R10";
      4'd7: return "R7 R10";
      4'd11: return "R8";
      4'd12: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [3:0] f);
    logic [7:0] exp_r;
    @(posedge clk);
    a = x; b = y; fn = f;
    @(negedge clk);
    exp_r = model(x, y, f);
    checks++;
    if (res !== exp_r) begin
      fails++;
      $display("FAIL %s fn=%0d a=%h b=%h result actual=%h expected=%h",
               req_of(f), f, x, y, res, exp_r);
    end
    checks++;
    if (eq !== (x == y)) begin
      fails++;
      $display("FAIL R11 fn=%0d a=%h b=%h equal actual=%b expected=%b",
               f, x, y, eq, (x == y));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed = 32'h5a17;
    void'($urandom(seed));
    a = '0; b = '0; fn = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // quiescent state: zero operands
    apply(8'h00, 8'h00, 4'd0);               // R1 R11
    apply(8'hFF, 8'h01, 4'd0);               // R1 wrap
    apply(8'h00, 8'h01, 4'd1);               // R2 wrap
    apply(8'hA5, 8'h5A, 4'd2);               // R3
    apply(8'hA5, 8'h5A, 4'd3);               // R3
    apply(8'h81, 8'h0F, 4'd4);               // R4 R10: amount 7 from 0x0F
    apply(8'h81, 8'h09, 4'd4);               // R10: 9 wraps to 1
    apply(8'h7F, 8'h80, 4'd5);               // R5: 127 < -128 false
    apply(8'h80, 8'h7F, 4'd5);               // R5: true
    apply(8'h80, 8'hF8, 4'd6);               // R10: amount 0
    apply(8'h80, 8'h07, 4'd6);               // R6
    apply(8'h80, 8'h07, 4'd7);               // R7
    apply(8'hC3, 8'h0A, 4'd7);               // R7 R10
    apply(8'h12, 8'h3C, 4'd11);              // R8
    apply(8'hEE, 8'h3C, 4'd11);              // R8 a ignored
    apply(8'h12, 8'h00, 4'd12);              // R9 zero
    apply(8'h77, 8'h80, 4'd12);              // R9
    apply(8'hFF, 8'hFF, 4'd1);               // R11 equal
    for (int f = 0; f < 16; f++) apply(8'h5C, 8'hE3, 4'(f)); // R12 sweep
    for (int i = 0; i < 4000; i++)
      apply(8'($urandom), ((i % 5) == 0) ? 8'($urandom) & 8'hF0 | 8'(i) & 8'h0F
                                         : 8'($urandom), 4'($urandom));
    for (int i = 0; i < 64; i++) apply(8'(i * 3), 8'(i * 3), 4'($urandom)); // R11
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule